// File: doc/BRIEF.md
# Multi-Mode Programmable Logic Cell

This block is a single cell of a lookup-table fabric. A 16-bit table mask can act as one 4-input function or as two 3-input functions. The cell also has a fast carry path, a cascade path and a flip-flop with asynchronous clear and preset. Static configuration inputs select one of four modes: plain logic, arithmetic, up/down counter or clearable counter. The same inputs hold the table mask, choose whether the fourth table input is the carry-in or data line 3, and choose whether the cell output comes from the flip-flop or directly from the logic.

Counters and adders wider than one bit are built by joining cells. Each cell's carry-out drives the next cell's carry-in, and the first cell's carry-in is tied high. For wide AND functions, cells are chained through the cascade path, and the cascade input of the first cell is tied high.

Top module: `logic_cell`

## Requirements
- R1: In plain logic mode (cfg_mode = 0) the table address is {sel3, data[2], data[1], data[0]}, with sel3 at bit 3. sel3 is carry_in when cfg_use_carry = 1 and data[3] otherwise. The looked-up mask bit drives the logic result.
- R2: In plain logic and arithmetic modes, the logic result is ANDed with casc_in. casc_out carries that gated value.
- R3: When cfg_registered = 1, cell_out shows the flip-flop state. When cfg_registered = 0, cell_out shows the combinational result. In plain logic and arithmetic modes the flip-flop captures the gated result on each rising clock edge.
- R4: In arithmetic mode (cfg_mode = 1), the result is mask[{carry_in, data[1], data[0]}], gated by casc_in, and carry_out is mask[8 + {carry_in, data[1], data[0]}].
- R5: In both counter modes (cfg_mode = 2 up/down, 3 clearable), the count result is mask[{q, carry_in, data[1]}] and carry_out is mask[8 + {q, carry_in, dir}]. data[1] is the count enable. dir is casc_in in mode 2 and 1 in mode 3. With the counter masks 0x8478, a chain counts up for dir = 1, counts down for dir = 0 and holds when the enable is 0.
- R6: In counter modes, data[3] = 1 makes the flip-flop load data[2] on the clock edge instead of the count result.
- R7: In clearable counter mode, casc_in = 1 makes the flip-flop load 0 on the clock edge. The clear overrides both the load and the count.
- R8: rst_n low or aclr high forces the flip-flop to 0 at once, with no clock edge. Otherwise apre high forces it to 1 at once. Both asynchronous controls override the clock.
- R9: carry_out is 0 in plain logic mode. casc_out is 0 in both counter modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop |
| cfg_mode | input | 2 | Operating mode: 0 logic, 1 arithmetic, 2 up/down counter, 3 clearable counter |
| cfg_mask | input | 16 | Lookup table contents; bits 7:0 lower half, 15:8 upper half |
| cfg_use_carry | input | 1 | Plain logic mode: take carry_in instead of data[3] as table input 3 |
| cfg_registered | input | 1 | Select flip-flop state for cell_out |
| data | input | 4 | Data inputs from local routing |
| carry_in | input | 1 | Carry from the previous cell |
| casc_in | input | 1 | Cascade input; direction or synchronous clear in counter modes |
| aclr | input | 1 | Asynchronous clear of the flip-flop |
| apre | input | 1 | Asynchronous preset of the flip-flop |
| cell_out | output | 1 | Cell data output |
| carry_out | output | 1 | Carry to the next cell |
| casc_out | output | 1 | Cascade output to the next cell |

## Verification
The bench runs a 4-bit counter chain through wraparound in both directions. A cell that drew its carry from the wrong table half, or used the wrong direction bit, would count wrongly at 15→0 and 0→15. It loads and clears at the same time, which catches a clear placed ahead of the load multiplexer instead of after it. It also raises preset and clear together between clock edges, which exposes a swapped priority or a synchronous-only clear. Random mode, mask and input patterns check the table address order, and with it the carry-versus-data3 choice and the cascade gating.

// File: rtl/logic_cell_pkg.sv
package logic_cell_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC  = 2'd0,
    MODE_ARITH  = 2'd1,
    MODE_UPDN   = 2'd2,
    MODE_CLRCNT = 2'd3
  } cell_mode_e;
endpackage

// File: rtl/cell_table.sv
module cell_table #(
  parameter int ADDR_W = 4,
  localparam int MASK_W = 1 << ADDR_W
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [ADDR_W-1:0] full_addr,
  input  logic [ADDR_W-2:0] lo_addr,
  input  logic [ADDR_W-2:0] hi_addr,
  output logic              full_bit,
  output logic              lo_bit,
  output logic              hi_bit
);
  localparam int HALF_W = MASK_W / 2;

  logic [HALF_W-1:0] lo_half;
  logic [HALF_W-1:0] hi_half;

  always_comb begin
    lo_half  = mask[HALF_W-1:0];
    hi_half  = mask[MASK_W-1:HALF_W];
    full_bit = mask[full_addr];
    lo_bit   = lo_half[lo_addr];
    hi_bit   = hi_half[hi_addr];
  end
endmodule

// File: rtl/cell_flop.sv
module cell_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic aclr,
  input  logic apre,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n or posedge aclr or posedge apre) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (aclr) begin
      q <= 1'b0;
    end else if (apre) begin
      q <= 1'b1;
    end else begin
      q <= d;
    end
  end

  AST_ACLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    aclr |-> !q); // R8
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (apre && !aclr) |-> q); // R8
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import logic_cell_pkg::*;
#(
  parameter int LUT_IN = 4,
  localparam int MASK_W = 1 << LUT_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              cfg_use_carry,
  input  logic              cfg_registered,
  input  logic [LUT_IN-1:0] data,
  input  logic              carry_in,
  input  logic              casc_in,
  input  logic              aclr,
  input  logic              apre,
  output logic              cell_out,
  output logic              carry_out,
  output logic              casc_out
);
  localparam int TOP = LUT_IN - 1;

  cell_mode_e        mode;
  logic [LUT_IN-1:0] full_addr;
  logic [LUT_IN-2:0] lo_addr;
  logic [LUT_IN-2:0] hi_addr;
  logic              full_bit;
  logic              lo_bit;
  logic              hi_bit;
  logic              sel3;
  logic              cnt_en;
  logic              ld_val;
  logic              ld_strobe;
  logic              cnt_dir;
  logic              sync_clr;
  logic              comb_res;
  logic              load_mux;
  logic              d_next;
  logic              q;

  assign mode = cell_mode_e'(cfg_mode);

  // counter-mode field mapping
  always_comb begin
    cnt_en    = data[1];
    ld_val    = data[2];
    ld_strobe = data[TOP];
    cnt_dir   = (mode == MODE_UPDN) ? casc_in : 1'b1;
    sync_clr  = (mode == MODE_CLRCNT) && casc_in;
  end

  // table addressing
  always_comb begin
    sel3      = cfg_use_carry ? carry_in : data[TOP];
    full_addr = {sel3, data[TOP-1:0]};
    if (mode == MODE_LOGIC || mode == MODE_ARITH) begin
      lo_addr = {carry_in, data[1], data[0]};
      hi_addr = {carry_in, data[1], data[0]};
    end else begin
      lo_addr = {q, carry_in, cnt_en};
      hi_addr = {q, carry_in, cnt_dir};
    end
  end

  cell_table #(.ADDR_W(LUT_IN)) u_table (
    .mask      (cfg_mask),
    .full_addr (full_addr),
    .lo_addr   (lo_addr),
    .hi_addr   (hi_addr),
    .full_bit  (full_bit),
    .lo_bit    (lo_bit),
    .hi_bit    (hi_bit)
  );

  // next-state and chain outputs
  always_comb begin
    load_mux = ld_strobe ? ld_val : lo_bit;
    unique case (mode)
      MODE_LOGIC: begin
        comb_res  = full_bit & casc_in;
        carry_out = 1'b0;
        casc_out  = comb_res;
        d_next    = comb_res;
      end
      MODE_ARITH: begin
        comb_res  = lo_bit & casc_in;
        carry_out = hi_bit;
        casc_out  = comb_res;
        d_next    = comb_res;
      end
      default: begin
        comb_res  = lo_bit;
        carry_out = hi_bit;
        casc_out  = 1'b0;
        d_next    = load_mux & ~sync_clr;
      end
    endcase
    cell_out = cfg_registered ? q : comb_res;
  end

  cell_flop u_flop (
    .clk   (clk),
    .rst_n (rst_n),
    .aclr  (aclr),
    .apre  (apre),
    .d     (d_next),
    .q     (q)
  );

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0) |-> !carry_out); // R9
  AST_COUNT_NO_CASC: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[1] |-> !casc_out); // R9
  AST_CASC_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode[1] && !casc_in) |-> !casc_out); // R2
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd3 && casc_in && !aclr && !apre) |=> (!q || apre)); // R7
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2 && data[TOP] && !aclr && !apre)
      |=> (q == $past(data[2]) || aclr || apre)); // R6
endmodule

// File: tb/logic_cell_tb.sv
module logic_cell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CHAIN = 4;
  localparam logic [15:0] CNT_MASK = 16'h8478;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_mask;
  logic        cfg_use_carry, cfg_registered;
  logic [3:0]  data;
  logic        carry_in, casc_in, aclr, apre;
  logic        cell_out, carry_out, casc_out;

  int tests = 0;
  int fails = 0;
  logic q_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_mask(cfg_mask),
    .cfg_use_carry(cfg_use_carry), .cfg_registered(cfg_registered),
    .data(data), .carry_in(carry_in), .casc_in(casc_in), .aclr(aclr),
    .apre(apre), .cell_out(cell_out), .carry_out(carry_out), .casc_out(casc_out)
  );

  // counter chain
  logic [1:0]       ch_mode;
  logic             ch_en, ch_ld, ch_casc;
  logic [CHAIN-1:0] ch_ldv, ch_out, ch_cy, ch_cso;

  for (genvar i = 0; i < CHAIN; i++) begin : g_chain
    logic cin_i;
    if (i == 0) begin : g_first
      assign cin_i = 1'b1;
    end else begin : g_rest
      assign cin_i = ch_cy[i-1];
    end
    logic_cell u_cell (
      .clk(clk), .rst_n(rst_n), .cfg_mode(ch_mode), .cfg_mask(CNT_MASK),
      .cfg_use_carry(1'b0), .cfg_registered(1'b1),
      .data({ch_ld, ch_ldv[i], ch_en, 1'b0}), .carry_in(cin_i),
      .casc_in(ch_casc), .aclr(1'b0), .apre(1'b0),
      .cell_out(ch_out[i]), .carry_out(ch_cy[i]), .casc_out(ch_cso[i])
    );
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // returns {out, cout, cso, dnext}
  function automatic logic [3:0] model(input logic [1:0] m, input logic [15:0] mk,
      input logic uc, input logic rg, input logic [3:0] d, input logic ci,
      input logic cs, input logic q);
    logic comb, co, so, dn, dir;
    case (m)
      2'd0: begin
        comb = mk[{uc ? ci : d[3], d[2:0]}] & cs;
        co = 1'b0; so = comb; dn = comb;
      end
      2'd1: begin
        comb = mk[{1'b0, ci, d[1], d[0]}] & cs;
        co = mk[{1'b1, ci, d[1], d[0]}]; so = comb; dn = comb;
      end
      default: begin
        dir  = (m == 2'd2) ? cs : 1'b1;
        comb = mk[{1'b0, q, ci, d[1]}];
        co   = mk[{1'b1, q, ci, dir}];
        so   = 1'b0;
        dn   = (m == 2'd3 && cs) ? 1'b0 : (d[3] ? d[2] : comb);
      end
    endcase
    return {rg ? q : comb, co, so, dn};
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] r;
    int cnt;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_mode = 2'd0; cfg_mask = 16'h0; cfg_use_carry = 1'b0;
    cfg_registered = 1'b1; data = 4'h0; carry_in = 1'b0; casc_in = 1'b1;
    aclr = 1'b0; apre = 1'b0; q_exp = 1'b0;
    ch_mode = 2'd2; ch_en = 1'b0; ch_ld = 1'b0; ch_casc = 1'b1; ch_ldv = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset state", int'(cell_out), 0);
    chk("R8 chain reset", int'(ch_out), 0);
    rst_n = 1'b1;

    // directed: carry-vs-data3 selection
    @(negedge clk);
    cfg_registered = 1'b0; cfg_mode = 2'd0; cfg_mask = 16'hFF00;
    data = 4'h0; carry_in = 1'b1; cfg_use_carry = 1'b1; casc_in = 1'b1;
    #1 chk("R1 carry as input 3", int'(cell_out), 1);
    cfg_use_carry = 1'b0;
    #1 chk("R1 data3 as input 3", int'(cell_out), 0);
    data = 4'h8; casc_in = 1'b0;
    #1 chk("R2 cascade gating", int'(casc_out), 0);
    casc_in = 1'b1;
    #1 chk("R2 cascade pass", int'(casc_out), 1);
    @(posedge clk); #1 q_exp = 1'b1;

    // random patterns
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      cfg_mode = 2'($urandom % 4);
      cfg_mask = ($urandom % 3 == 0) ? CNT_MASK : 16'($urandom);
      cfg_use_carry = 1'($urandom); cfg_registered = 1'($urandom);
      data = 4'($urandom); carry_in = 1'($urandom); casc_in = 1'($urandom);
      #1;
      r = model(cfg_mode, cfg_mask, cfg_use_carry, cfg_registered, data,
                carry_in, casc_in, q_exp);
      chk(cfg_registered ? "R3 out" : {mode_tag(cfg_mode), " out"}, int'(cell_out), int'(r[3]));
      chk({mode_tag(cfg_mode), " carry_out R9"}, int'(carry_out), int'(r[2]));
      chk("R2 R9 casc_out", int'(casc_out), int'(r[1]));
      @(posedge clk); #1 q_exp = r[0];
    end

    // asynchronous controls
    @(negedge clk);
    cfg_mode = 2'd0; cfg_registered = 1'b1; cfg_mask = 16'h0000; apre = 1'b1;
    #2 chk("R8 preset no clock", int'(cell_out), 1);
    aclr = 1'b1;
    #2 chk("R8 clear beats preset", int'(cell_out), 0);
    @(posedge clk); #1 chk("R8 clear beats clock", int'(cell_out), 0);
    @(negedge clk); aclr = 1'b0; apre = 1'b0;

    // counter chain
    @(negedge clk); ch_mode = 2'd2; ch_casc = 1'b1; ch_en = 1'b1;
    ch_ld = 1'b1; ch_ldv = 4'd14;
    @(negedge clk); chk("R6 chain load", int'(ch_out), 14);
    ch_ld = 1'b0; cnt = 14;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); cnt = (cnt + 1) % 16;
      chk("R5 count up wrap", int'(ch_out), cnt);
    end
    ch_casc = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); cnt = (cnt + 15) % 16;
      chk("R5 count down wrap", int'(ch_out), cnt);
    end
    chk("R9 counter casc_out", int'(ch_cso), 0);
    ch_en = 1'b0;
    @(negedge clk); chk("R5 enable low holds", int'(ch_out), cnt);
    ch_mode = 2'd3; ch_en = 1'b1; ch_casc = 1'b0;
    @(negedge clk); cnt = (cnt + 1) % 16;
    chk("R7 clearable counts up", int'(ch_out), cnt);
    ch_casc = 1'b1; ch_ld = 1'b1; ch_ldv = 4'd9;
    @(negedge clk); chk("R7 clear beats load", int'(ch_out), 0);
    ch_casc = 1'b0;
    @(negedge clk); chk("R6 clearable load", int'(ch_out), 9);

    summary();
    $finish;
  end
endmodule